// File: doc/BRIEF.md
# Interface PHY Self-Test Controller

This block runs a built-in self-test on the data-path front end of a storage-card PHY. While the self-test enable is low, the host controller's transmit word passes straight through to the front end. While the enable is high, the controller takes over the front-end data input. It sends bursts of a known pseudo-random pattern through a loopback model of the receive path. It then compares each returned word with a locally delayed copy of the expected word.

A sequence starts on a rising edge of the start input and runs in the mode selected at that edge. The two 200 MHz single-rate modes step the receive-clock delay tap from 0 to 31 and record one pass bit per tap. Every other defined mode makes one check at a fixed nominal tap and reports a single pass bit. When the sequence ends, the done flag rises. It stays high, with the status frozen, until software lowers start. The loopback path is a stub with a configurable latency and a configurable window of good taps (the "eye"). A word received outside that window has bit 0 flipped.

Top module: `phy_selftest_ctrl`

## Requirements
- R1: While `st_enable` is low, `fe_data_o` equals `host_data_i` in the same cycle, and a rising edge of `st_start` does not start a sequence (`done_o` stays 0).
- R2: While `st_enable` is high, the controller drives `fe_data_o`. The value is 0 outside pattern bursts, whatever `host_data_i` holds.
- R3: A sequence begins only on a rising edge of `st_start` sampled while idle. `st_mode` is captured at that edge, and later changes to it do not affect the running sequence.
- R4: Once `done_o` is 1, it stays 1 and `status_o` stays unchanged for as long as `st_start` is held high.
- R5: On the first clock edge that samples `st_start` low while `done_o` is 1, `done_o` returns to 0.
- R6: Modes 4'b0000 and 4'b0001 sweep taps 0 to 31 in ascending order. Each tap gets a 4-cycle settle period, and then 64 PRBS-7 bytes are checked. `status_o[n]` is 1 exactly when all 64 bytes matched at tap n.
- R7: Modes 4'b0010 to 4'b0111 run one 64-byte check at the nominal tap. `status_o[0]` is 1 on a full match, and `status_o[31:1]` is 0.
- R8: Modes 4'b1000 to 4'b1111 are reserved. A start in a reserved mode sets `done_o` on the next clock edge, with `status_o` all zero.
- R9: `status_o` is cleared to zero at the edge that accepts a start, and it stays zero until the first result of the new sequence is recorded.
- R10: After reset, `done_o` is 0 and `status_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| st_enable | input | 1 | Self-test takes over the front-end data path when high |
| st_mode | input | 4 | Test mode select |
| st_start | input | 1 | Rising edge starts a sequence |
| host_data_i | input | 8 | Host controller transmit word |
| fe_data_o | output | 8 | Word presented to the PHY front end |
| done_o | output | 1 | Sequence complete, held until start falls |
| status_o | output | 32 | Per-tap or single pass result |

## Verification
The bench builds two copies of the block and drives both with the same stimulus. The first copy uses a 3-cycle loopback latency, a good-tap window of 10 to 20 and nominal tap 15. In that copy the sweep result has interior edges on both sides, and the single-check modes pass. The second copy uses a 1-cycle latency, a window of 5 to 31 and nominal tap 2. This brings tap 31 and a failing tap 0 into the sweep, makes every single-check mode fail, and exercises the latency alignment at its shortest depth.

// File: rtl/phy_st_pkg.sv
package phy_st_pkg;

    localparam int DATA_W   = 8;
    localparam int NUM_TAPS = 32;
    localparam int TAP_W    = $clog2(NUM_TAPS);

    typedef enum logic [2:0] {
        S_IDLE,
        S_SETTLE,
        S_SEND,
        S_DRAIN,
        S_RECORD,
        S_DONE
    } st_state_e;

    typedef struct packed {
        logic [6:0]        lfsr;
        logic [DATA_W-1:0] word;
    } prbs_step_t;

    // Advance a PRBS-7 register (x^7 + x^6 + 1) by one byte.
    function automatic prbs_step_t prbs7_byte(input logic [6:0] s);
        prbs_step_t r;
        logic       fb;
        r.lfsr = s;
        r.word = '0;
        for (int i = 0; i < DATA_W; i++) begin
            fb     = r.lfsr[6] ^ r.lfsr[5];
            r.word = {r.word[DATA_W-2:0], fb};
            r.lfsr = {r.lfsr[5:0], fb};
        end
        return r;
    endfunction

    function automatic logic mode_is_sweep(input logic [3:0] m);
        return (m == 4'b0000) || (m == 4'b0001);
    endfunction

    function automatic logic mode_is_reserved(input logic [3:0] m);
        return m[3];
    endfunction

endpackage

// File: rtl/st_delay_line.sv
module st_delay_line #(
    parameter int W     = 8,
    parameter int DEPTH = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] pipe [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) pipe[i] <= '0;
        end else begin
            pipe[0] <= d;
            for (int i = 1; i < DEPTH; i++) pipe[i] <= pipe[i-1];
        end
    end

    assign q = pipe[DEPTH-1];
endmodule

// File: rtl/st_prbs_gen.sv
module st_prbs_gen
    import phy_st_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reseed,
    input  logic              advance,
    output logic [DATA_W-1:0] word_o
);
    logic [6:0] lfsr;
    prbs_step_t nxt;

    always_comb nxt = prbs7_byte(lfsr);
    assign word_o = nxt.word;

    always_ff @(posedge clk) begin
        if (rst || reseed) lfsr <= 7'h7F;
        else if (advance)  lfsr <= nxt.lfsr;
    end
endmodule

// File: rtl/st_loopback_stub.sv
module st_loopback_stub
    import phy_st_pkg::*;
#(
    parameter int LAT    = 3,
    parameter int EYE_LO = 10,
    parameter int EYE_HI = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [TAP_W-1:0]  tap,
    input  logic [DATA_W-1:0] tx,
    output logic [DATA_W-1:0] rx
);
    logic [DATA_W-1:0] delayed;
    logic              in_eye;

    st_delay_line #(.W(DATA_W), .DEPTH(LAT)) u_path (
        .clk(clk), .rst(rst), .d(tx), .q(delayed)
    );

    assign in_eye = (int'(tap) >= EYE_LO) && (int'(tap) <= EYE_HI);
    assign rx     = in_eye ? delayed : (delayed ^ DATA_W'(1));
endmodule

// File: rtl/phy_selftest_ctrl.sv
module phy_selftest_ctrl
    import phy_st_pkg::*;
#(
    parameter int WORDS   = 64,
    parameter int SETTLE  = 4,
    parameter int LAT     = 3,
    parameter int EYE_LO  = 10,
    parameter int EYE_HI  = 20,
    parameter int NOM_TAP = 15
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                st_enable,
    input  logic [3:0]          st_mode,
    input  logic                st_start,
    input  logic [DATA_W-1:0]   host_data_i,
    output logic [DATA_W-1:0]   fe_data_o,
    output logic                done_o,
    output logic [NUM_TAPS-1:0] status_o
);
    localparam int WCNT_W = $clog2(WORDS);
    localparam int SCNT_W = $clog2(SETTLE + 1);
    localparam int DCNT_W = $clog2(LAT + 2);

    st_state_e          state;
    logic               start_q;
    logic [3:0]         mode_q;
    logic [TAP_W-1:0]   tap;
    logic               tap_fail;
    logic [SCNT_W-1:0]  settle_cnt;
    logic [WCNT_W-1:0]  word_cnt;
    logic [DCNT_W-1:0]  drain_cnt;

    logic               sending;
    logic [DATA_W-1:0]  gen_word;
    logic [DATA_W-1:0]  tx_word;
    logic [DATA_W-1:0]  rx_word;
    logic [DATA_W:0]    exp_dly;
    logic               start_rise;

    assign sending    = (state == S_SEND);
    assign tx_word    = sending ? gen_word : '0;
    assign fe_data_o  = st_enable ? tx_word : host_data_i;
    assign start_rise = st_start && !start_q;
    assign done_o     = (state == S_DONE);

    st_prbs_gen u_gen (
        .clk(clk), .rst(rst), .reseed(!sending), .advance(sending), .word_o(gen_word)
    );

    st_loopback_stub #(.LAT(LAT), .EYE_LO(EYE_LO), .EYE_HI(EYE_HI)) u_loop (
        .clk(clk), .rst(rst), .tap(tap), .tx(fe_data_o), .rx(rx_word)
    );

    // Expected-word alignment: same latency as the loopback path.
    st_delay_line #(.W(DATA_W + 1), .DEPTH(LAT)) u_expect (
        .clk(clk), .rst(rst), .d({sending, gen_word}), .q(exp_dly)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= S_IDLE;
            start_q    <= 1'b0;
            mode_q     <= '0;
            tap        <= '0;
            tap_fail   <= 1'b0;
            settle_cnt <= '0;
            word_cnt   <= '0;
            drain_cnt  <= '0;
            status_o   <= '0;
        end else begin
            start_q <= st_start;
            if (exp_dly[DATA_W] && (rx_word != exp_dly[DATA_W-1:0]))
                tap_fail <= 1'b1;

            if (!st_enable) begin
                state <= S_IDLE;
            end else begin
                unique case (state)
                    S_IDLE: if (start_rise) begin
                        mode_q     <= st_mode;
                        status_o   <= '0;
                        tap_fail   <= 1'b0;
                        settle_cnt <= '0;
                        tap        <= mode_is_sweep(st_mode) ? '0 : TAP_W'(NOM_TAP);
                        state      <= mode_is_reserved(st_mode) ? S_DONE : S_SETTLE;
                    end
                    S_SETTLE: begin
                        settle_cnt <= settle_cnt + 1'b1;
                        if (settle_cnt == SCNT_W'(SETTLE - 1)) begin
                            word_cnt <= '0;
                            state    <= S_SEND;
                        end
                    end
                    S_SEND: begin
                        word_cnt <= word_cnt + 1'b1;
                        if (word_cnt == WCNT_W'(WORDS - 1)) begin
                            drain_cnt <= '0;
                            state     <= S_DRAIN;
                        end
                    end
                    S_DRAIN: begin
                        drain_cnt <= drain_cnt + 1'b1;
                        if (drain_cnt == DCNT_W'(LAT)) state <= S_RECORD;
                    end
                    S_RECORD: begin
                        if (mode_is_sweep(mode_q)) begin
                            status_o[tap] <= !tap_fail;
                            if (tap == TAP_W'(NUM_TAPS - 1)) begin
                                state <= S_DONE;
                            end else begin
                                tap        <= tap + 1'b1;
                                tap_fail   <= 1'b0;
                                settle_cnt <= '0;
                                state      <= S_SETTLE;
                            end
                        end else begin
                            status_o[0] <= !tap_fail;
                            state       <= S_DONE;
                        end
                    end
                    S_DONE: if (!st_start) state <= S_IDLE;
                    default: state <= S_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/st_selftest_chk.sv
module st_selftest_chk
    import phy_st_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                st_enable,
    input logic [3:0]          st_mode,
    input logic                st_start,
    input logic                done_o,
    input logic [NUM_TAPS-1:0] status_o,
    input st_state_e           state,
    input logic                start_q,
    input logic [3:0]          mode_q
);
    // R1
    enable_low_inactive_chk: assert property (@(posedge clk) disable iff (rst)
        !st_enable |=> !done_o);

    // R4
    done_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (done_o && st_start && st_enable) |=> (done_o && $stable(status_o)));

    // R5
    done_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (done_o && !st_start) |=> !done_o);

    // R7
    single_bit_only_chk: assert property (@(posedge clk) disable iff (rst)
        (done_o && !mode_is_sweep(mode_q)) |-> (status_o[NUM_TAPS-1:1] == '0));

    // R8
    reserved_quick_chk: assert property (@(posedge clk) disable iff (rst)
        (state == S_IDLE && st_enable && st_start && !start_q && st_mode[3])
        |=> (done_o && status_o == '0));

    // R9
    status_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (state == S_IDLE && st_enable && st_start && !start_q) |=> (status_o == '0));
endmodule

bind phy_selftest_ctrl st_selftest_chk u_chk (.*);

// File: tb/tb_phy_selftest_ctrl.sv
module tb_phy_selftest_ctrl;
    logic        clk = 1'b0;
    logic        rst;
    logic        st_enable;
    logic [3:0]  st_mode;
    logic        st_start;
    logic [7:0]  host_data_i;
    logic [7:0]  fe_a, fe_b;
    logic        done_a, done_b;
    logic [31:0] stat_a, stat_b;

    int tests = 0;
    int fails = 0;

    always #5 clk = ~clk;

    phy_selftest_ctrl dut (
        .clk(clk), .rst(rst), .st_enable(st_enable), .st_mode(st_mode),
        .st_start(st_start), .host_data_i(host_data_i),
        .fe_data_o(fe_a), .done_o(done_a), .status_o(stat_a)
    );

    phy_selftest_ctrl #(.LAT(1), .EYE_LO(5), .EYE_HI(31), .NOM_TAP(2)) dut_b (
        .clk(clk), .rst(rst), .st_enable(st_enable), .st_mode(st_mode),
        .st_start(st_start), .host_data_i(host_data_i),
        .fe_data_o(fe_b), .done_o(done_b), .status_o(stat_b)
    );

    function automatic logic [31:0] eye_mask(input int lo, input int hi);
        logic [31:0] m = '0;
        for (int n = 0; n < 32; n++) if (n >= lo && n <= hi) m[n] = 1'b1;
        return m;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Per-clock reference: with enable low the front end follows the host.
    always @(negedge clk) begin
        if (!rst && !st_enable) begin
            check("R1 passthrough a", {24'd0, fe_a}, {24'd0, host_data_i});
            check("R1 passthrough b", {24'd0, fe_b}, {24'd0, host_data_i});
        end
    end

    task automatic wait_done(output bit ok);
        ok = 0;
        for (int i = 0; i < 6000; i++) begin
            @(negedge clk);
            if (done_a && done_b) begin ok = 1; break; end
        end
    endtask

    task automatic run_mode(input logic [3:0] m, input logic [31:0] ea,
                            input logic [31:0] eb, input string req);
        bit ok;
        logic [31:0] ha, hb;
        @(negedge clk);
        st_mode  = m;
        st_start = 1'b1;
        wait_done(ok);
        check({req, " done reached"}, {31'd0, ok}, 32'd1);
        check({req, " status a"}, stat_a, ea);
        check({req, " status b"}, stat_b, eb);
        ha = stat_a; hb = stat_b;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            // R4: done and status held while start is high
            check("R4 done hold", {30'd0, done_a, done_b}, 32'd3);
            check("R4 status stable", stat_a ^ ha | stat_b ^ hb, 32'd0);
        end
        st_start = 1'b0;
        @(negedge clk);
        // R5: one edge later done is low
        check("R5 done clears", {30'd0, done_a, done_b}, 32'd0);
    endtask

    initial begin
        bit ok;
        rst = 1'b1; st_enable = 1'b0; st_mode = 4'd0; st_start = 1'b0; host_data_i = 8'h00;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10
        check("R10 reset done", {30'd0, done_a, done_b}, 32'd0);
        check("R10 reset status", stat_a | stat_b, 32'd0);

        // R1: host words pass through, start ignored with enable low
        for (int v = 0; v < 4; v++) begin
            @(negedge clk);
            host_data_i = 8'(8'h3C + v * 8'h41);
        end
        st_start = 1'b1;
        repeat (200) @(negedge clk);
        check("R1 no start while disabled", {30'd0, done_a, done_b}, 32'd0);
        st_start = 1'b0;
        @(negedge clk);

        // R2: controller owns the data path when enabled
        host_data_i = 8'hA5;
        st_enable   = 1'b1;
        @(negedge clk);
        check("R2 idle drive a", {24'd0, fe_a}, 32'd0);
        check("R2 idle drive b", {24'd0, fe_b}, 32'd0);

        // R6: both sweep modes
        run_mode(4'b0000, eye_mask(10, 20), eye_mask(5, 31), "R6 sweep 0000");
        run_mode(4'b0001, eye_mask(10, 20), eye_mask(5, 31), "R6 sweep 0001");

        // R7: every single-check mode
        for (int m = 2; m < 8; m++)
            run_mode(4'(m), 32'd1, 32'd0, "R7 single");

        // R9: status cleared at start, zero while running
        run_mode(4'b0000, eye_mask(10, 20), eye_mask(5, 31), "R6 sweep again");
        @(negedge clk);
        st_mode = 4'b0011; st_start = 1'b1;
        repeat (10) @(negedge clk);
        check("R9 status cleared", stat_a | stat_b, 32'd0);
        // R3: mode change mid-run has no effect
        st_mode = 4'b0000;
        wait_done(ok);
        check("R3 latched mode a", stat_a, 32'd1);
        check("R3 latched mode b", stat_b, 32'd0);
        st_start = 1'b0;
        @(negedge clk);

        // R3: no restart while start stays high and no new edge
        @(negedge clk);
        st_start = 1'b1; st_mode = 4'b0101;
        wait_done(ok);
        st_mode = 4'b0000;
        repeat (300) @(negedge clk);
        check("R3 no restart without edge", stat_a, 32'd1);
        st_start = 1'b0;
        @(negedge clk);

        // R8: reserved mode completes after one edge with zero status
        @(negedge clk);
        st_mode = 4'b1010; st_start = 1'b1;
        @(negedge clk);
        check("R8 reserved done", {30'd0, done_a, done_b}, 32'd3);
        check("R8 reserved status", stat_a | stat_b, 32'd0);
        st_start = 1'b0;
        @(negedge clk);
        check("R5 clear after reserved", {30'd0, done_a, done_b}, 32'd0);

        // R1: dropping enable aborts and restores passthrough
        st_start = 1'b1; st_mode = 4'b0000;
        repeat (30) @(negedge clk);
        st_enable = 1'b0; host_data_i = 8'h5A;
        repeat (5) @(negedge clk);
        check("R1 abort done", {30'd0, done_a, done_b}, 32'd0);
        check("R1 abort passthrough", {24'd0, fe_a}, 32'h5A);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule